// File: doc/BRIEF.md
# Integer Execution ALU

This block is the arithmetic and logic stage of a small load/store integer core. It is purely combinational. It takes two source words, a shift count taken from an instruction field, and an operation code. It returns one result word and a zero flag. The adder serves ordinary add and subtract. It also forms load and store addresses from a base register plus an offset. The compare operation produces a 0/1 word, so a following equality branch on that word can act on a signed ordering.

The zero flag is high whenever the result word is all zeros. A branch-if-equal or branch-if-not-equal is implemented by issuing a subtract and testing this flag. Shifts act on the second source, and their count comes only from the shift-count input. The first source does not take part in a shift.

Top module: `alu_exec`

## Requirements
- R1: With `op_sel` = 0 (add), `result` equals `src_a + src_b` modulo 2^32.
- R2: With `op_sel` = 1 (subtract), `result` equals `src_a - src_b` modulo 2^32.
- R3: With `op_sel` = 2, `result` is the bitwise AND of the sources. With `op_sel` = 3, it is the bitwise OR. Example: 0xDF5A48F5 AND 0xF0F0F0F0 gives 0xD05040F0.
- R4: With `op_sel` = 4 (set-less-than), `result` is 1 when `src_a` is less than `src_b` as two's-complement signed values, and 0 otherwise. This holds even when the difference overflows, for example 0x7FFFFFFF against 0x80000000 gives 0.
- R5: With `op_sel` = 5 (shift left), `result` is `src_b` moved up by `shamt` places with zeros entering at bit 0. `src_a` has no effect. Example: 0xDF5A48F5 shifted by 8 gives 0x5A48F500, and a shift by 2 multiplies by 4.
- R6: With `op_sel` = 6 (logical shift right), `result` is `src_b` moved down by `shamt` places with zeros entering at bit 31. Example: 0x5A48F500 shifted by 4 gives 0x05A48F50.
- R7: A shift with `shamt` = 0 returns `src_b` unchanged.
- R8: `zero` is 1 exactly when `result` is all zeros. A subtract of equal sources therefore raises it.
- R9: The unused code `op_sel` = 7 yields `result` = 0 and `zero` = 1.
- R10: For codes 0 to 4, `shamt` has no effect on `result` or `zero`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code: 0 add, 1 sub, 2 and, 3 or, 4 slt, 5 sll, 6 srl, 7 unused |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand; the shifted word for shifts |
| shamt | input | 5 | Shift count from the instruction field |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The bench builds the block with its default width of 32 bits and a 5-bit shift count. At that size every one of the 32 shift counts and both sign-bit boundaries of the compare can be reached directly. Directed vectors cover the counts 0, 1 and 31, and the overflow pairs where a naive sign test of the difference gives the wrong ordering. Seeded random words are then spread over all eight codes, including the unused one.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int ALU_W    = 32;
    localparam int ALU_SH_W = $clog2(ALU_W);

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_SLT  = 3'd4,
        OP_SLL  = 3'd5,
        OP_SRL  = 3'd6,
        OP_NONE = 3'd7
    } alu_op_e;

    // Subtract path is shared by SUB and the signed compare
    function automatic logic uses_subtract(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SLT);
    endfunction

    function automatic logic is_shift(alu_op_e op);
        return (op == OP_SLL) || (op == OP_SRL);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic              sub_en,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] sum,
    output logic              lt_signed
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic              ovf;

    always_comb begin
        b_eff = opnd_b ^ {DATA_W{sub_en}};
        sum   = opnd_a + b_eff + {{(DATA_W-1){1'b0}}, sub_en};
        // overflow: operands agree in sign, sum disagrees
        ovf   = (opnd_a[MSB] == b_eff[MSB]) && (sum[MSB] != opnd_a[MSB]);
        lt_signed = sum[MSB] ^ ovf;
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = 5,
    parameter bit LEFT    = 1'b1
) (
    input  logic [DATA_W-1:0]  din,
    input  logic [SHAMT_W-1:0] amount,
    output logic [DATA_W-1:0]  dout
);
    logic [DATA_W-1:0] stage [SHAMT_W+1];

    assign stage[0] = din;

    // log2 barrel: stage i moves by 2^i places when count bit i is set
    for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
        if (LEFT) begin : g_left
            assign stage[i+1] = amount[i] ? (stage[i] << (1 << i)) : stage[i];
        end else begin : g_right
            assign stage[i+1] = amount[i] ? (stage[i] >> (1 << i)) : stage[i];
        end
    end

    assign dout = stage[SHAMT_W];
endmodule

// File: rtl/alu_exec.sv
module alu_exec
    import alu_pkg::*;
#(
    parameter int DATA_W  = ALU_W,
    parameter int SHAMT_W = ALU_SH_W
) (
    input  logic [2:0]         op_sel,
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [DATA_W-1:0]  result,
    output logic               zero
);
    alu_op_e           op;
    logic [DATA_W-1:0] arith_sum;
    logic              arith_lt;
    logic [DATA_W-1:0] shl_out;
    logic [DATA_W-1:0] shr_out;

    assign op = alu_op_e'(op_sel);

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .sub_en    (uses_subtract(op)),
        .opnd_a    (src_a),
        .opnd_b    (src_b),
        .sum       (arith_sum),
        .lt_signed (arith_lt)
    );

    alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .LEFT(1'b1)) u_shl (
        .din    (src_b),
        .amount (shamt),
        .dout   (shl_out)
    );

    alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .LEFT(1'b0)) u_shr (
        .din    (src_b),
        .amount (shamt),
        .dout   (shr_out)
    );

    always_comb begin
        unique case (op)
            OP_ADD,
            OP_SUB:  result = arith_sum;                               // R1 R2
            OP_AND:  result = src_a & src_b;                           // R3
            OP_OR:   result = src_a | src_b;                           // R3
            OP_SLT:  result = {{(DATA_W-1){1'b0}}, arith_lt};          // R4
            OP_SLL:  result = shl_out;                                 // R5
            OP_SRL:  result = shr_out;                                 // R6
            default: result = '0;                                      // R9
        endcase
    end

    assign zero = (result == '0);                                      // R8
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk
    import alu_pkg::*;
#(
    parameter int DATA_W  = ALU_W,
    parameter int SHAMT_W = ALU_SH_W
) (
    input logic [2:0]         op_sel,
    input logic [DATA_W-1:0]  src_a,
    input logic [DATA_W-1:0]  src_b,
    input logic [SHAMT_W-1:0] shamt,
    input logic [DATA_W-1:0]  result,
    input logic               zero
);
    logic [DATA_W-1:0] low_mask;
    logic [DATA_W-1:0] high_mask;
    alu_op_e           op;

    always_comb begin
        op        = alu_op_e'(op_sel);
        low_mask  = ~({DATA_W{1'b1}} << shamt);
        high_mask = ~({DATA_W{1'b1}} >> shamt);

        AST_SLT_IS_BOOL: assert (op != OP_SLT || result[DATA_W-1:1] == '0);            // R4
        AST_SLL_ZERO_FILL: assert (op != OP_SLL || (result & low_mask) == '0);         // R5
        AST_SRL_ZERO_FILL: assert (op != OP_SRL || (result & high_mask) == '0);        // R6
        AST_SHIFT_PASS: assert (!(is_shift(op) && shamt == '0) || result == src_b);    // R7
        AST_SUB_EQUAL_ZERO: assert (!(op == OP_SUB && src_a == src_b) || zero);        // R8
        AST_UNUSED_CODE: assert (op != OP_NONE || (result == '0 && zero));             // R9
    end
endmodule

bind alu_exec alu_exec_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (.*);

// File: tb/alu_exec_test.sv
module alu_exec_test;

    localparam int W  = 32;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    op_sel = '0;
    logic [W-1:0]  src_a = '0;
    logic [W-1:0]  src_b = '0;
    logic [SW-1:0] shamt = '0;
    logic [W-1:0]  result;
    logic          zero;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    alu_exec uut (
        .op_sel (op_sel),
        .src_a  (src_a),
        .src_b  (src_b),
        .shamt  (shamt),
        .result (result),
        .zero   (zero)
    );

    function automatic logic [W-1:0] model(input logic [2:0] op, input logic [W-1:0] a,
                                           input logic [W-1:0] b, input logic [SW-1:0] sh);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            3'd5: return b << sh;
            3'd6: return b >> sh;
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2, 3'd3: return "R3";
            3'd4: return "R4";
            3'd5: return "R5";
            3'd6: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [SW-1:0] sh, input string req);
        logic [W-1:0] exp_r;
        logic         exp_z;
        @(negedge clk);
        op_sel = op; src_a = a; src_b = b; shamt = sh;
        #1;
        exp_r = model(op, a, b, sh);
        exp_z = (exp_r == '0);
        n_vec++;
        if (result !== exp_r || zero !== exp_z) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got result=%h zero=%b, expected result=%h zero=%b",
                     req, op, a, b, sh, result, zero, exp_r, exp_z);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0]    rop;
        logic [W-1:0]  ra;
        logic [W-1:0]  rb;
        logic [SW-1:0] rs;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // idle state: all-zero inputs
        apply(3'd0, 32'h0, 32'h0, 5'd0, "R8 idle");
        apply(3'd0, 32'hFFFF_FFFF, 32'h1, 5'd0, "R1 wrap");
        apply(3'd0, 32'h1000_0000, 32'h0000_04B0, 5'd0, "R1 address");
        apply(3'd1, 32'h0, 32'h1, 5'd0, "R2 borrow");
        apply(3'd1, 32'h1234_5678, 32'h1234_5678, 5'd0, "R2 R8 equal");
        apply(3'd2, 32'hDF5A_48F5, 32'hF0F0_F0F0, 5'd0, "R3 and");
        apply(3'd3, 32'hD050_40F0, 32'h0000_00FC, 5'd0, "R3 or");
        apply(3'd4, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0, "R4 ovf pos");
        apply(3'd4, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, "R4 ovf neg");
        apply(3'd4, 32'hFFFF_FFFF, 32'h0, 5'd0, "R4 neg one");
        apply(3'd4, 32'h5, 32'h5, 5'd0, "R4 equal");
        apply(3'd5, 32'hAAAA_AAAA, 32'hDF5A_48F5, 5'd8, "R5 example");
        apply(3'd5, 32'h0, 32'h0000_0007, 5'd2, "R5 times4");
        apply(3'd5, 32'h0, 32'h0000_0003, 5'd31, "R5 max");
        apply(3'd6, 32'hFFFF_FFFF, 32'h5A48_F500, 5'd4, "R6 example");
        apply(3'd6, 32'h0, 32'h8000_0000, 5'd31, "R6 max");
        apply(3'd5, 32'h0, 32'hDEAD_BEEF, 5'd0, "R7 sll");
        apply(3'd6, 32'h0, 32'hDEAD_BEEF, 5'd0, "R7 srl");
        apply(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd9, "R9 unused");
        for (int op = 0; op < 5; op++) begin
            apply(3'(op), 32'h8765_4321, 32'h0F0F_1234, 5'd0, "R10 sh0");
            apply(3'(op), 32'h8765_4321, 32'h0F0F_1234, 5'd31, "R10 sh31");
        end
        for (int s = 0; s < 32; s++) begin
            apply(3'd5, 32'h0, 32'hC3A5_0F81, 5'(s), "R5 sweep");
            apply(3'd6, 32'h0, 32'hC3A5_0F81, 5'(s), "R6 sweep");
        end

        for (int i = 0; i < 3000; i++) begin
            rop = 3'($urandom);
            ra  = $urandom;
            rb  = $urandom;
            rs  = 5'($urandom);
            if (i % 10 == 0) rb = ra;   // equal operands exercise zero and compare
            apply(rop, ra, rb, rs, tag_of(rop));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule